// File: doc/BRIEF.md
# Serial Configuration Latch Decoder

This block is the serial write port of a 48-channel LED driver. A 49-bit shift register takes one bit per qualified serial clock edge at its least significant end. Its most significant bit is driven back out so that several drivers can be chained on one data line. A latch strobe commits the shifted word. The strobe is brought into the serial clock domain through two flip-flops, and only its rising edge acts.

The top bit of the word picks the destination. When it is clear, the lower 48 bits go to the per-channel on/off latch, and that latch is split into red, green and blue channel vectors. When it is set, the next eight bits must hold the command code 0x96. Bits 39 down to 3 then go to a latch that holds a 16-bit function field and three 7-bit brightness fields. Bits 2 to 0 go to a 3-bit pre-stage. The 3-bit current-limit value takes effect only when two guarded writes in a row carry the same value.

An asynchronous active-low reset stands in for undervoltage lockout and clears every register.

Top module: `serial_cfg_latch`

## Requirements
- R1: While shift_en is high, each clk edge moves the register up one place and loads sin into bit 0. sout always shows bit 48, so a bit comes out 49 qualified edges after it went in.
- R2: With rst_n low, the shift register, the on/off latch, the function and brightness latch, the current-limit pre-stage and the current-limit latch all read zero.
- R3: A strobe rising edge with bit 48 clear copies bits 47..0 into the on/off latch. The latch updates on the second clk edge after the strobe is first sampled.
- R4: The on/off latch drives on_red[n] from bit 3n, on_green[n] from bit 3n+1 and on_blue[n] from bit 3n+2, for n = 0..15.
- R5: A strobe rising edge with bit 48 set and bits 47..40 equal to 0x96 loads four fields. func_cfg gets bits 39..24, bri_blue gets 23..17, bri_green gets 16..10 and bri_red gets 9..3.
- R6: A strobe rising edge with bit 48 set and bits 47..40 not equal to 0x96 changes none of: the on/off latch, the function and brightness latch, the pre-stage, the current limit.
- R7: Every guarded write stores bits 2..0 in the pre-stage. cur_limit takes bits 2..0 only when they equal the pre-stage value left by the previous guarded write.
- R8: A write to the on/off latch leaves the brightness, function and current-limit state unchanged. A guarded write leaves the on/off latch unchanged.
- R9: Holding the strobe high does not latch again. Words shifted in while the strobe stays high are not committed until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low undervoltage reset |
| shift_en | input | 1 | Qualifies clk edges that shift |
| sin | input | 1 | Serial data in |
| strobe | input | 1 | Latch strobe, asynchronous to clk |
| sout | output | 1 | Serial data out (bit 48) |
| on_red | output | 16 | Red channel on/off bits |
| on_green | output | 16 | Green channel on/off bits |
| on_blue | output | 16 | Blue channel on/off bits |
| func_cfg | output | 16 | Function control field |
| bri_blue | output | 7 | Blue brightness |
| bri_green | output | 7 | Green brightness |
| bri_red | output | 7 | Red brightness |
| cur_limit | output | 3 | Committed current-limit code |

## Verification
The assertions run on every cycle and check the routing rules. Without a strobe edge no latch moves. A select-clear commit copies the shift word. A bad command byte leaves the brightness latch and the pre-stage untouched. The current limit moves only on a guarded write whose value matches the pre-stage. The bench's scenarios are needed to show what the assertions cannot: the serial shift order, the channel bit mapping, the reset mid-sequence, and the rule that a held strobe commits nothing more. These run through random frame sequences with repeated current-limit codes.

// File: rtl/serial_cfg_latch.sv
module serial_cfg_latch #(
  parameter int        CH      = 16,
  parameter int        BRI_W   = 7,
  parameter logic [7:0] CMD    = 8'h96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 sin,
  input  logic                 strobe,
  output logic                 sout,
  output logic [CH-1:0]        on_red,
  output logic [CH-1:0]        on_green,
  output logic [CH-1:0]        on_blue,
  output logic [15:0]          func_cfg,
  output logic [BRI_W-1:0]     bri_blue,
  output logic [BRI_W-1:0]     bri_green,
  output logic [BRI_W-1:0]     bri_red,
  output logic [2:0]           cur_limit
);
  localparam int ON_W = 3 * CH;
  localparam int SRW  = ON_W + 1;
  localparam int BF_W = ON_W - 11;

  logic [SRW-1:0]  sr;
  logic [2:0]      stb_q;
  logic [ON_W-1:0] onoff;
  logic [BF_W-1:0] bf;
  logic [2:0]      pre;

  wire pulse    = stb_q[1] & ~stb_q[2];
  wire sel_hi   = sr[SRW-1];
  wire cmd_ok   = (sr[ON_W-1 -: 8] == CMD);
  wire guard_wr = pulse & sel_hi & cmd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      stb_q     <= '0;
      onoff     <= '0;
      bf        <= '0;
      pre       <= '0;
      cur_limit <= '0;
    end else begin
      stb_q <= {stb_q[1:0], strobe};
      if (shift_en) sr <= {sr[SRW-2:0], sin};
      if (pulse && !sel_hi) onoff <= sr[ON_W-1:0];
      if (guard_wr) begin
        bf  <= sr[ON_W-9:3];
        pre <= sr[2:0];
        if (sr[2:0] == pre) cur_limit <= sr[2:0];
      end
    end
  end

  assign sout = sr[SRW-1];

  for (genvar n = 0; n < CH; n++) begin : g_ch
    assign on_red[n]   = onoff[3*n];
    assign on_green[n] = onoff[3*n+1];
    assign on_blue[n]  = onoff[3*n+2];
  end

  assign func_cfg  = bf[BF_W-1 -: 16];
  assign bri_blue  = bf[3*BRI_W-1 -: BRI_W];
  assign bri_green = bf[2*BRI_W-1 -: BRI_W];
  assign bri_red   = bf[BRI_W-1:0];

  // R3
  onoff_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !sel_hi) |=> (onoff == $past(sr[ON_W-1:0])));
  // R8
  onoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse && !sel_hi) |=> $stable(onoff));
  // R6
  badcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && sel_hi && !cmd_ok) |=> ($stable(bf) && $stable(pre) && $stable(cur_limit)));
  // R7
  limit_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_wr |=> $stable(cur_limit));
  // R7
  limit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_wr && sr[2:0] != pre) |=> $stable(cur_limit));
endmodule

// File: tb/serial_cfg_latch_bench.sv
module serial_cfg_latch_bench;
  logic clk = 0, rst_n = 0, shift_en = 0, sin = 0, strobe = 0;
  logic sout;
  logic [15:0] on_red, on_green, on_blue, func_cfg;
  logic [6:0] bri_blue, bri_green, bri_red;
  logic [2:0] cur_limit;

  int errs = 0, checks = 0;
  logic [48:0] m_sr;
  logic [47:0] m_on;
  logic [36:0] m_bf;
  logic [2:0]  m_pre, m_lim;

  always #4 clk = ~clk;

  serial_cfg_latch u_serial_cfg_latch (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sin(sin), .strobe(strobe),
    .sout(sout), .on_red(on_red), .on_green(on_green), .on_blue(on_blue),
    .func_cfg(func_cfg), .bri_blue(bri_blue), .bri_green(bri_green),
    .bri_red(bri_red), .cur_limit(cur_limit));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [47:0] v, input int ofs);
    logic [15:0] r;
    for (int n = 0; n < 16; n++) r[n] = v[3*n+ofs];
    return r;
  endfunction

  task automatic check_all(input string req);
    chk({req, " R4 red"},   on_red,   pick(m_on, 0));
    chk({req, " R4 green"}, on_green, pick(m_on, 1));
    chk({req, " R4 blue"},  on_blue,  pick(m_on, 2));
    chk({req, " R5 func"},  func_cfg, m_bf[36:21]);
    chk({req, " R5 bri"},   {bri_blue, bri_green, bri_red}, m_bf[20:0]);
    chk({req, " R7 limit"}, cur_limit, m_lim);
  endtask

  task automatic shift_frame(input logic [48:0] f);
    logic [48:0] outs;
    for (int i = 48; i >= 0; i--) begin
      @(negedge clk);
      outs[i] = sout;
      shift_en = 1; sin = f[i];
    end
    @(negedge clk);
    shift_en = 0;
    chk("R1 sout stream", outs, m_sr);
    m_sr = f;
    chk("R1 sout msb", sout, f[48]);
  endtask

  task automatic model_commit();
    if (!m_sr[48]) m_on = m_sr[47:0];
    else if (m_sr[47:40] == 8'h96) begin
      m_bf = m_sr[39:3];
      if (m_sr[2:0] == m_pre) m_lim = m_sr[2:0];
      m_pre = m_sr[2:0];
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk); strobe = 1;
    repeat (4) @(negedge clk);
    strobe = 0;
    repeat (2) @(negedge clk);
    model_commit();
  endtask

  task automatic model_reset();
    m_sr = '0; m_on = '0; m_bf = '0; m_pre = '0; m_lim = '0;
  endtask

  function automatic logic [48:0] guarded(input logic [36:0] body, input logic [2:0] lim);
    return {1'b1, 8'h96, body, lim};
  endfunction

  initial begin
    #800000;
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [48:0] f;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R2 reset");
    chk("R2 sout", sout, 1'b0);
    rst_n = 1;

    // R3/R4 directed single-channel patterns
    shift_frame({1'b0, 48'h0000_0000_0001}); pulse_strobe(); check_all("R3 red0");
    shift_frame({1'b0, 48'h8000_0000_0002}); pulse_strobe(); check_all("R3 blue15 green0");
    // R5 guarded write, R8 onoff untouched
    shift_frame(guarded(37'h1A_BCDE_F123 & 37'h1F_FFFF_FFFF, 3'd5)); pulse_strobe();
    check_all("R5 R8 guarded");
    // R7 second identical write commits
    shift_frame(guarded(37'h05_5555_5555, 3'd5)); pulse_strobe(); check_all("R7 commit");
    // R6 bad command
    shift_frame({1'b1, 8'h95, 37'h1F_FFFF_FFFF, 3'd2}); pulse_strobe(); check_all("R6 badcmd");
    shift_frame(guarded(37'h0, 3'd2)); pulse_strobe(); check_all("R6 pre kept");
    // R8 onoff write leaves limit/bf
    shift_frame({1'b0, 48'hFFFF_FFFF_FFFF}); pulse_strobe(); check_all("R8 onoff only");
    // R9 held strobe: second frame not committed
    @(negedge clk); strobe = 1;
    repeat (4) @(negedge clk);
    model_commit();
    shift_frame({1'b0, 48'h1234_5678_9ABC});
    repeat (4) @(negedge clk);
    check_all("R9 held");
    strobe = 0; repeat (2) @(negedge clk);
    pulse_strobe(); check_all("R9 next edge");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int sel = $urandom_range(0, 3);
      logic [2:0] lim = 3'($urandom_range(0, 2));
      logic [36:0] body = {5'($urandom), 32'($urandom)};
      if (sel == 0) f = {1'b0, 16'($urandom), 32'($urandom)};
      else if (sel == 3) f = {1'b1, 8'($urandom_range(0, 255)), body, lim};
      else f = guarded(body, lim);
      shift_frame(f); pulse_strobe(); check_all("R3 R5 R6 R7 random");
    end

    // R2 reset mid-run
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk);
    check_all("R2 midrun");
    chk("R2 sout midrun", sout, 1'b0);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule